// File: doc/BRIEF.md
# Dual-clock show-ahead FIFO buffer

This block is a first-in first-out buffer of 512 words by 18 bits that carries data between two free-running clocks. The clocks may be unrelated or the same. A producer in the write clock domain offers a word with two enables. The buffer takes it when input-ready is high. A consumer in the read clock domain sees the oldest word already sitting in an output register, flagged by output-ready, and takes it with its read enables.

The read port is show-ahead. The first word stored into an empty buffer moves to the output register by itself, with no read request. The write-side valid is the active-high write enable together with the active-low write enable, and the ready is input-ready. The read-side valid is output-ready, and the ready is all active-low read enables low. On either side a transfer happens only on a clock edge where valid and ready are both high. The side that offers a word keeps it stable until the transfer, so a stalled producer simply holds its word and a stalled consumer keeps seeing the same output word.

The write clock domain also provides a half-full flag and a combined almost-full/almost-empty flag. The almost flag uses an offset that is captured from a dedicated port while reset is held. Reset is asynchronous and must cover at least four rising edges of each clock. Pointers cross between the clock domains in Gray code, so the flags are conservative: they may lag the true state, but never allow an overrun or an underrun.

Top module: `twoclk_fifo`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wr_en` is 1, `wr_en_n` is 0 and `in_rdy` is 1; any other combination stores nothing.
- R2: The buffer holds at most 512 words, counting the word in the output register; `in_rdy` is 0 while 512 words are held, and no stored word is ever overwritten.
- R3: A word is taken on a rising read-clock edge only when every bit of `rd_en_n` is 0 and `out_rdy` is 1; with any enable bit at 1, `rd_data` and `out_rdy` do not change because of the read port.
- R4: When `out_rdy` is 0 and a stored word has reached the read domain, that word is loaded into `rd_data` and `out_rdy` rises, whatever the level of `rd_en_n`.
- R5: While `out_rdy` is 1 and no word is taken, `rd_data` and `out_rdy` hold their values.
- R6: Words leave in exactly the order they were stored, each exactly once.
- R7: While `arst_n` is 0, `in_rdy`, `out_rdy` and `half_full` are 0 and `almost_flag` is 1; `in_rdy` rises within a few write clocks after release.
- R8: `half_full` is 1 when the write-domain word count is 257 or more and 0 when it is 256 or less.
- R9: `almost_flag` is 1 when the write-domain word count is at most the offset or at least 512 minus the offset; the offset is taken from `almost_ofs` while reset is held.
- R10: When the last held word is taken and nothing else is stored, `out_rdy` falls on that read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, free-running |
| wr_en | input | 1 | Write enable, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Word offered for storage |
| in_rdy | output | 1 | Room for at least one word (write domain) |
| half_full | output | 1 | Count of 257 or more (write domain) |
| almost_flag | output | 1 | Count near empty or near full by the offset (write domain) |
| rd_clk | input | 1 | Read clock, free-running |
| rd_en_n | input | 2 | Read enables, active low, all must be low to take |
| rd_data | output | 18 | Output register holding the oldest word |
| out_rdy | output | 1 | rd_data holds a valid word (read domain) |
| arst_n | input | 1 | Asynchronous reset, active low |
| almost_ofs | input | 9 | Almost-flag offset, captured during reset |

## Verification
On the read side, one edge can hand the output word to the consumer and refill the output register from storage. The bench provokes this by streaming with both read enables held low, or toggled on alternate read clocks, while words are still pending in storage. A scoreboard fed by the write driver must see every word exactly once and in order. On the write side, a write can land on the same edge that brings in a new copy of the read pointer near the full mark. Filling to capacity and then draining shows `in_rdy` dropping at exactly 512 words and the flags returning as the count falls.

// File: rtl/twf_pkg.sv
package twf_pkg;
  localparam int unsigned CODE_W = 32;

  function automatic logic [CODE_W-1:0] bin2gray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] gray2bin(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/twf_sync.sv
module twf_sync #(
  parameter int unsigned W  = 1,
  parameter logic        RV = 1'b0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1 <= {W{RV}};
      q      <= {W{RV}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/twf_store.sv
module twf_store #(
  parameter int unsigned W  = 18,
  parameter int unsigned AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/twf_wr_side.sv
module twf_wr_side #(
  parameter int unsigned AW = 9
) (
  input  logic          wr_clk,
  input  logic          arst_n,
  input  logic          wrst,
  input  logic          push_req,
  input  logic [AW:0]   rc_gray_s,
  input  logic [AW-1:0] ofs_in,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0]   wp_gray,
  output logic          in_rdy,
  output logic          half_full,
  output logic          almost_flag
);
  import twf_pkg::*;

  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [PW-1:0]     wp_bin, wp_nx, rc_bin, cnt, cnt_nx, hi_mark;
  logic [CODE_W-1:0] rc_wide;
  logic [AW-1:0]     ofs_q;

  assign rc_wide = gray2bin(CODE_W'(rc_gray_s));
  assign rc_bin  = rc_wide[PW-1:0];
  assign wr_fire = push_req & in_rdy;
  assign wp_nx   = wp_bin + PW'(wr_fire);
  assign cnt     = wp_bin - rc_bin;
  assign cnt_nx  = wp_nx - rc_bin;
  assign hi_mark = FULL_CNT - {1'b0, ofs_q};
  assign wr_addr = wp_bin[AW-1:0];

  // offset is captured only while the write domain is in reset
  always_ff @(posedge wr_clk) begin
    if (wrst) ofs_q <= ofs_in;
  end

  always_ff @(posedge wr_clk or negedge arst_n) begin
    if (!arst_n) begin
      wp_bin      <= '0;
      wp_gray     <= '0;
      in_rdy      <= 1'b0;
      half_full   <= 1'b0;
      almost_flag <= 1'b1;
    end else if (wrst) begin
      in_rdy      <= 1'b0;
      half_full   <= 1'b0;
      almost_flag <= 1'b1;
    end else begin
      wp_bin      <= wp_nx;
      wp_gray     <= PW'(bin2gray(CODE_W'(wp_nx)));
      in_rdy      <= (cnt_nx < FULL_CNT);
      half_full   <= (cnt_nx > HALF_CNT);
      almost_flag <= (cnt_nx <= {1'b0, ofs_q}) || (cnt_nx >= hi_mark);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (wrst)
    cnt <= FULL_CNT);

  // R2
  full_block_chk: assert property (@(posedge wr_clk) disable iff (wrst)
    (cnt == FULL_CNT) |-> !in_rdy);

  // R7
  always @(posedge wr_clk) begin
    if (wrst) begin
      wr_reset_flags_chk: assert (!in_rdy && !half_full && almost_flag);
    end
  end
endmodule

// File: rtl/twf_rd_side.sv
module twf_rd_side #(
  parameter int unsigned W   = 18,
  parameter int unsigned AW  = 9,
  parameter int unsigned NRE = 2
) (
  input  logic           rd_clk,
  input  logic           arst_n,
  input  logic           rrst,
  input  logic [AW:0]    wp_gray_s,
  input  logic [NRE-1:0] rd_en_n,
  input  logic [W-1:0]   ram_q,
  output logic [AW-1:0]  rd_addr,
  output logic [AW:0]    rc_gray,
  output logic [W-1:0]   rd_data,
  output logic           out_rdy
);
  import twf_pkg::*;

  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0]     rf_bin, rc_bin, ws_bin, rc_nx;
  logic [CODE_W-1:0] ws_wide;
  logic              avail, take, load;

  assign ws_wide = gray2bin(CODE_W'(wp_gray_s));
  assign ws_bin  = ws_wide[PW-1:0];
  assign avail   = (ws_bin != rf_bin);
  assign take    = out_rdy & ~(|rd_en_n);
  assign load    = avail & (~out_rdy | take);
  assign rc_nx   = rc_bin + PW'(take);
  assign rd_addr = rf_bin[AW-1:0];

  always_ff @(posedge rd_clk or negedge arst_n) begin
    if (!arst_n) begin
      rf_bin  <= '0;
      rc_bin  <= '0;
      rc_gray <= '0;
      rd_data <= '0;
      out_rdy <= 1'b0;
    end else if (rrst) begin
      out_rdy <= 1'b0;
    end else begin
      if (load) begin
        rd_data <= ram_q;
        rf_bin  <= rf_bin + 1'b1;
      end
      out_rdy <= load | (out_rdy & ~take);
      rc_bin  <= rc_nx;
      rc_gray <= PW'(bin2gray(CODE_W'(rc_nx)));
    end
  end

  // R3
  no_underrun_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    (ws_bin - rf_bin) <= PW'(DEPTH));

  // R4
  fall_through_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    (!out_rdy && avail) |=> out_rdy);

  // R5
  hold_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    (out_rdy && !take) |=> (out_rdy && $stable(rd_data)));

  // R10
  last_take_chk: assert property (@(posedge rd_clk) disable iff (rrst)
    (take && !avail) |=> !out_rdy);

  // R7
  always @(posedge rd_clk) begin
    if (rrst) begin
      rd_reset_flags_chk: assert (!out_rdy);
    end
  end
endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo #(
  parameter int unsigned DATA_W   = 18,
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned NUM_RDEN = 2
) (
  input  logic                wr_clk,
  input  logic                wr_en,
  input  logic                wr_en_n,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                in_rdy,
  output logic                half_full,
  output logic                almost_flag,
  input  logic                rd_clk,
  input  logic [NUM_RDEN-1:0] rd_en_n,
  output logic [DATA_W-1:0]   rd_data,
  output logic                out_rdy,
  input  logic                arst_n,
  input  logic [ADDR_W-1:0]   almost_ofs
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              wrst, rrst, wr_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0]     wp_gray, wp_gray_s, rc_gray, rc_gray_s;
  logic [DATA_W-1:0] ram_q;

  twf_sync #(.W(1), .RV(1'b1)) u_wrst (
    .clk(wr_clk), .arst_n(arst_n), .d(1'b0), .q(wrst));

  twf_sync #(.W(1), .RV(1'b1)) u_rrst (
    .clk(rd_clk), .arst_n(arst_n), .d(1'b0), .q(rrst));

  twf_sync #(.W(PW), .RV(1'b0)) u_wp2r (
    .clk(rd_clk), .arst_n(arst_n), .d(wp_gray), .q(wp_gray_s));

  twf_sync #(.W(PW), .RV(1'b0)) u_rc2w (
    .clk(wr_clk), .arst_n(arst_n), .d(rc_gray), .q(rc_gray_s));

  twf_store #(.W(DATA_W), .AW(ADDR_W)) u_store (
    .wclk(wr_clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(ram_q));

  twf_wr_side #(.AW(ADDR_W)) u_wr (
    .wr_clk(wr_clk), .arst_n(arst_n), .wrst(wrst),
    .push_req(wr_en & ~wr_en_n), .rc_gray_s(rc_gray_s), .ofs_in(almost_ofs),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wp_gray(wp_gray),
    .in_rdy(in_rdy), .half_full(half_full), .almost_flag(almost_flag));

  twf_rd_side #(.W(DATA_W), .AW(ADDR_W), .NRE(NUM_RDEN)) u_rd (
    .rd_clk(rd_clk), .arst_n(arst_n), .rrst(rrst), .wp_gray_s(wp_gray_s),
    .rd_en_n(rd_en_n), .ram_q(ram_q), .rd_addr(rd_addr), .rc_gray(rc_gray),
    .rd_data(rd_data), .out_rdy(out_rdy));
endmodule

// File: tb/sim_twoclk_fifo.sv
`timescale 1ns/1ps
module sim_twoclk_fifo;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_en = 1'b0, wr_en_n = 1'b1;
  logic [17:0] wr_data = '0;
  logic        in_rdy, half_full, almost_flag, out_rdy;
  logic [1:0]  rd_en_n = 2'b11;
  logic [17:0] rd_data;
  logic        arst_n = 1'b1;
  logic [8:0]  almost_ofs = 9'd64;

  int checks = 0, errors = 0;
  int rd_pat = 0, rph = 0, vcount = 0;
  logic [17:0] scb[$];
  logic [17:0] first_word;

  twoclk_fifo u0 (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .in_rdy(in_rdy), .half_full(half_full), .almost_flag(almost_flag),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_data(rd_data), .out_rdy(out_rdy),
    .arst_n(arst_n), .almost_ofs(almost_ofs));

  always #5 wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // read driver and scoreboard monitor (R3, R6)
  always @(negedge rd_clk) begin
    rph++;
    case (rd_pat)
      1:       rd_en_n = 2'b00;
      2:       rd_en_n = rph[0] ? 2'b00 : 2'b11;
      3:       rd_en_n = rph[0] ? 2'b01 : 2'b10;
      default: rd_en_n = 2'b11;
    endcase
    if (out_rdy && rd_en_n == 2'b00) begin
      if (scb.size() == 0) begin
        check("R6 unexpected word", 32'(rd_data), 32'hFFFFFFFF);
      end else begin
        check("R6 order", 32'(rd_data), 32'(scb.pop_front()));
      end
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge wr_clk);
  endtask

  // driver: called at a write-clock falling edge
  task automatic push(input logic [17:0] d);
    wr_data = d; wr_en = 1'b1; wr_en_n = 1'b0;
    while (!in_rdy) @(negedge wr_clk);
    scb.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0; wr_en_n = 1'b1;
  endtask

  function automatic logic [17:0] next_val();
    vcount++;
    return 18'(vcount * 37 + 5);
  endfunction

  task automatic fill_to(input int n);
    while (scb.size() < n) push(next_val());
  endtask

  task automatic do_reset(input logic [8:0] ofs);
    rd_pat = 0;
    wr_en = 1'b0; wr_en_n = 1'b1;
    almost_ofs = ofs;
    arst_n = 1'b0;
    #100;
    check("R7 in_rdy in reset", 32'(in_rdy), 32'd0);
    check("R7 out_rdy in reset", 32'(out_rdy), 32'd0);
    check("R7 half_full in reset", 32'(half_full), 32'd0);
    check("R7 almost_flag in reset", 32'(almost_flag), 32'd1);
    scb.delete();
    arst_n = 1'b1;
    wcyc(6);
    check("R7 in_rdy after release", 32'(in_rdy), 32'd1);
    check("R7 almost_flag empty", 32'(almost_flag), 32'd1);
  endtask

  task automatic drain();
    int t = 0;
    rd_pat = 1;
    while (scb.size() != 0 && t < 20000) begin
      @(negedge rd_clk);
      t++;
    end
    repeat (6) @(negedge rd_clk);
    check("R6 all words out", 32'(scb.size()), 32'd0);
    check("R10 out_rdy after last take", 32'(out_rdy), 32'd0);
    @(negedge wr_clk);
  endtask

  initial begin
    #1_999_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    #2;
    @(negedge wr_clk);
    do_reset(9'd64);

    // fall-through without a read request
    first_word = next_val();
    push(first_word);
    repeat (10) @(negedge rd_clk);
    check("R4 out_rdy on first word", 32'(out_rdy), 32'd1);
    check("R4 first word shown", 32'(rd_data), 32'(first_word));

    // one enable low, one high: nothing taken
    rd_pat = 3;
    repeat (20) @(negedge rd_clk);
    check("R3 partial enable holds data", 32'(rd_data), 32'(first_word));
    check("R3 partial enable holds out_rdy", 32'(out_rdy), 32'd1);
    rd_pat = 0;
    @(negedge wr_clk);

    // gated writes must not be stored
    wr_data = 18'h3FFFF; wr_en = 1'b0; wr_en_n = 1'b0;
    wcyc(3);
    wr_en = 1'b1; wr_en_n = 1'b1;
    wcyc(3);
    wr_en = 1'b0;

    // flag thresholds with offset 64, no reads
    fill_to(64);  wcyc(3);
    check("R9 almost at count 64", 32'(almost_flag), 32'd1);
    fill_to(65);  wcyc(3);
    check("R9 almost at count 65", 32'(almost_flag), 32'd0);
    fill_to(256); wcyc(3);
    check("R8 half_full at 256", 32'(half_full), 32'd0);
    fill_to(257); wcyc(3);
    check("R8 half_full at 257", 32'(half_full), 32'd1);
    fill_to(447); wcyc(3);
    check("R9 almost at count 447", 32'(almost_flag), 32'd0);
    fill_to(448); wcyc(3);
    check("R9 almost at count 448", 32'(almost_flag), 32'd1);

    // fill until blocked (R1 gated writes would show as an early stop)
    for (int i = 0; i < 100; i++) begin
      if (!in_rdy) begin
        wcyc(8);
        if (!in_rdy) break;
      end
      push(next_val());
    end
    check("R2 R1 words held when full", 32'(scb.size()), 32'd512);
    check("R2 in_rdy low when full", 32'(in_rdy), 32'd0);
    check("R5 output held while full", 32'(rd_data), 32'(first_word));

    drain();
    wcyc(10);
    check("R8 half_full cleared when empty", 32'(half_full), 32'd0);
    check("R9 almost set when empty", 32'(almost_flag), 32'd1);
    check("R2 in_rdy back after drain", 32'(in_rdy), 32'd1);

    // streaming with take and refill on the same read edge
    rd_pat = 2;
    for (int i = 0; i < 300; i++) begin
      push(next_val());
      if (i % 7 == 3) wcyc(2);
      if (i == 150) rd_pat = 1;
    end
    drain();

    // reset with data inside, new offset
    rd_pat = 0;
    for (int i = 0; i < 20; i++) push(next_val());
    do_reset(9'd100);
    check("R7 out_rdy low after reset with data", 32'(out_rdy), 32'd0);
    fill_to(100); wcyc(3);
    check("R9 almost at count 100 offset 100", 32'(almost_flag), 32'd1);
    fill_to(101); wcyc(3);
    check("R9 almost at count 101 offset 100", 32'(almost_flag), 32'd0);
    drain();

    summary();
    $finish;
  end
endmodule